// File: doc/BRIEF.md
# Full-Bridge Transmit Burst Generator with Dead Time

This block makes the logic-level gate commands for an isolated full-bridge class-D transmitter. One start strobe from the ping sequencer launches a burst of a set number of square-wave carrier cycles. Each carrier cycle drives one diagonal of the bridge in its first half and the other diagonal in its second half. Every hand-over between the two drive lines is separated by a dead time in which neither line is active. A bridge-enable line is high only while a burst is running, and a one-clock done pulse marks the last clock of the burst.

The carrier period, the dead time, a power-trim value and the cycle count are all held as clock counts. With a 100 MHz clock the nominal settings are a period of 1000 counts (100 kHz), a dead time of 50 counts (0.5 µs) and 20 cycles (200 µs). The trim value shortens the trailing end of every active drive window, and this lowers the power delivered to the transducer. The sequencer sets the spacing between pings by choosing when to issue each start strobe. All settings are captured when the strobe is accepted, so a change written during a burst first applies to the next ping.

Top module: `fbridge_burst`

## Requirements
- R1: A start strobe sampled while idle, with a nonzero cycle count, begins a burst. The clock edge after the accepting edge is burst clock k=0. The outputs reflect burst clock k in the window after the following edge, and bridgeEn is high in every one of those windows.
- R2: bridgeHi and bridgeLo are never high in the same cycle. Between one of them falling and the other rising, both stay low for at least MIN_DEAD clocks.
- R3: The carrier phase c equals k mod P, and half = floor(P/2). bridgeHi is high exactly when D <= c and c + T < half, where P, D and T are the captured period, dead time and trim.
- R4: bridgeLo is high exactly when half + D <= c and c + T < P.
- R5: The captured dead time D is the larger of the requested dead time and MIN_DEAD (default 4). The captured period P is the larger of the requested period and 4*MIN_DEAD (default 16).
- R6: burstDone is high for exactly one cycle, in the window of the final burst clock k = N*P-1. In the following cycle burstDone, bridgeEn, bridgeHi and bridgeLo are all low.
- R7: A burst lasts exactly N*P clocks for a captured cycle count N, and it always ends on a complete carrier cycle.
- R8: A start strobe is ignored when the cycle count is zero. The block then stays idle with all outputs low.
- R9: While a burst runs, new start strobes and changes to any configuration input have no effect on the outputs. The next accepted start captures the new values.
- R10: During and right after reset, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock (100 MHz nominal) |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Ping launch strobe from the sequencer |
| cfgPeriod | input | PER_W | Carrier period in clocks |
| cfgDead | input | PER_W | Requested dead time in clocks |
| cfgTrim | input | PER_W | Clocks removed from the tail of each drive window |
| cfgCycles | input | CYC_W | Carrier cycles per burst |
| bridgeHi | output | 1 | Drive command for the first-half diagonal |
| bridgeLo | output | 1 | Drive command for the second-half diagonal |
| bridgeEn | output | 1 | Bridge enable, high during a burst |
| burstDone | output | 1 | One-clock pulse on the final burst clock |

## Verification
The assertions assume that startIn is a synchronous level that is known at every edge after reset. They also take a burst launch to mean startIn was high two edges before bridgeEn rises. Nothing is assumed about the configuration values, because the block clamps them itself. The stimulus drives startIn and the configuration only on falling clock edges, holds startIn high for a single clock, and keeps it low during reset. The random settings include requested dead times and periods below the clamp limits, so the clamping is exercised without breaking any assumption.

// File: rtl/fbridge_pkg.sv
package fbridge_pkg;
  typedef struct packed {
    logic load;    // capture settings, clear counters
    logic run;     // burst active this clock
    logic finish;  // final clock of the burst
  } ctlStrobe_t;
endpackage

// File: rtl/fbridge_ctrl.sv
module fbridge_ctrl
  import fbridge_pkg::*;
#(
  parameter int CYC_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [CYC_W-1:0] cfgCycles,
  input  logic             lastTick,
  output ctlStrobe_t       strobes
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t state, stateNext;

  always_comb begin
    strobes.load   = (state == ST_IDLE) && startIn && (cfgCycles != '0);
    strobes.run    = (state == ST_RUN);
    strobes.finish = (state == ST_RUN) && lastTick;
    stateNext = state;
    if (strobes.load)        stateNext = ST_RUN;
    else if (strobes.finish) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/fbridge_dp.sv
module fbridge_dp
  import fbridge_pkg::*;
#(
  parameter int PER_W    = 16,
  parameter int CYC_W    = 12,
  parameter int MIN_DEAD = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobes,
  input  logic [PER_W-1:0] cfgPeriod,
  input  logic [PER_W-1:0] cfgDead,
  input  logic [PER_W-1:0] cfgTrim,
  input  logic [CYC_W-1:0] cfgCycles,
  output logic             lastTick,
  output logic             bridgeHi,
  output logic             bridgeLo,
  output logic             bridgeEn,
  output logic             burstDone
);
  localparam int EXT_W = PER_W + 1;
  localparam logic [PER_W-1:0] DEAD_FLOOR = PER_W'(MIN_DEAD);
  localparam logic [PER_W-1:0] PER_FLOOR  = PER_W'(4 * MIN_DEAD);

  logic [PER_W-1:0] perLat, deadLat, trimLat, phase;
  logic [CYC_W-1:0] cycLat, cycCnt;
  logic [PER_W-1:0] deadEff, perEff;
  logic             phaseWrap;
  logic [EXT_W-1:0] phaseX, halfX, tailX;
  logic             hiWin, loWin;

  // R5: clamp settings on capture
  assign deadEff = (cfgDead   < DEAD_FLOOR) ? DEAD_FLOOR : cfgDead;
  assign perEff  = (cfgPeriod < PER_FLOOR)  ? PER_FLOOR  : cfgPeriod;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perLat  <= PER_FLOOR;
      deadLat <= DEAD_FLOOR;
      trimLat <= '0;
      cycLat  <= '0;
    end else if (strobes.load) begin
      perLat  <= perEff;
      deadLat <= deadEff;
      trimLat <= cfgTrim;
      cycLat  <= cfgCycles;
    end
  end

  assign phaseWrap = (phase == perLat - PER_W'(1));
  assign lastTick  = phaseWrap && (cycCnt == cycLat - CYC_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= '0;
      cycCnt <= '0;
    end else if (strobes.load) begin
      phase  <= '0;
      cycCnt <= '0;
    end else if (strobes.run) begin
      if (phaseWrap) begin
        phase  <= '0;
        cycCnt <= cycCnt + CYC_W'(1);
      end else begin
        phase  <= phase + PER_W'(1);
      end
    end
  end

  // R3/R4: drive windows inside one carrier period
  assign phaseX = {1'b0, phase};
  assign halfX  = {2'b0, perLat[PER_W-1:1]};
  assign tailX  = phaseX + {1'b0, trimLat};
  assign hiWin  = (phase >= deadLat) && (tailX < halfX);
  assign loWin  = (phaseX >= halfX + {1'b0, deadLat}) && (tailX < {1'b0, perLat});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bridgeHi  <= 1'b0;
      bridgeLo  <= 1'b0;
      bridgeEn  <= 1'b0;
      burstDone <= 1'b0;
    end else begin
      bridgeHi  <= strobes.run && hiWin;
      bridgeLo  <= strobes.run && loWin;
      bridgeEn  <= strobes.run;
      burstDone <= strobes.finish;
    end
  end
endmodule

// File: rtl/fbridge_burst.sv
module fbridge_burst
  import fbridge_pkg::*;
#(
  parameter int PER_W    = 16,
  parameter int CYC_W    = 12,
  parameter int MIN_DEAD = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [PER_W-1:0] cfgPeriod,
  input  logic [PER_W-1:0] cfgDead,
  input  logic [PER_W-1:0] cfgTrim,
  input  logic [CYC_W-1:0] cfgCycles,
  output logic             bridgeHi,
  output logic             bridgeLo,
  output logic             bridgeEn,
  output logic             burstDone
);
  ctlStrobe_t strobes;
  logic       lastTick;

  fbridge_ctrl #(.CYC_W(CYC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .cfgCycles(cfgCycles),
    .lastTick(lastTick), .strobes(strobes)
  );

  fbridge_dp #(.PER_W(PER_W), .CYC_W(CYC_W), .MIN_DEAD(MIN_DEAD)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cfgPeriod(cfgPeriod), .cfgDead(cfgDead), .cfgTrim(cfgTrim), .cfgCycles(cfgCycles),
    .lastTick(lastTick), .bridgeHi(bridgeHi), .bridgeLo(bridgeLo),
    .bridgeEn(bridgeEn), .burstDone(burstDone)
  );
endmodule

// File: rtl/fbridge_burst_chk.sv
module fbridge_burst_chk #(
  parameter int PER_W    = 16,
  parameter int MIN_DEAD = 4
) (
  input logic clk,
  input logic rstN,
  input logic startIn,
  input logic bridgeHi,
  input logic bridgeLo,
  input logic bridgeEn,
  input logic burstDone
);
  localparam logic [PER_W-1:0] SAT = '1;
  localparam logic [PER_W-1:0] GAP_MIN = PER_W'(MIN_DEAD);
  logic [PER_W-1:0] sinceHi, sinceLo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceHi <= SAT;
      sinceLo <= SAT;
    end else begin
      sinceHi <= bridgeHi ? '0 : ((sinceHi == SAT) ? SAT : sinceHi + PER_W'(1));
      sinceLo <= bridgeLo ? '0 : ((sinceLo == SAT) ? SAT : sinceLo + PER_W'(1));
    end
  end

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(bridgeHi && bridgeLo));
  a_r2_gap_before_lo: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bridgeLo) |-> sinceHi >= GAP_MIN);
  a_r2_gap_before_hi: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bridgeHi) |-> sinceLo >= GAP_MIN);
  a_r1_drive_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    !bridgeEn |-> !bridgeHi && !bridgeLo);
  a_r1_enable_follows_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bridgeEn) |-> $past(startIn, 2));
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |=> !burstDone);
  a_r6_quiet_after_done: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |=> !bridgeEn && !bridgeHi && !bridgeLo);
  a_r6_done_in_burst: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> bridgeEn);
endmodule

bind fbridge_burst fbridge_burst_chk #(.PER_W(PER_W), .MIN_DEAD(MIN_DEAD)) u_chk (
  .clk(clk), .rstN(rstN), .startIn(startIn), .bridgeHi(bridgeHi),
  .bridgeLo(bridgeLo), .bridgeEn(bridgeEn), .burstDone(burstDone)
);

// File: tb/fbridge_burst_tb.sv
module fbridge_burst_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PER_W = 16;
  localparam int CYC_W = 12;
  localparam int MIN_DEAD = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [PER_W-1:0] cfgPeriod = '0, cfgDead = '0, cfgTrim = '0;
  logic [CYC_W-1:0] cfgCycles = '0;
  logic bridgeHi, bridgeLo, bridgeEn, burstDone;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fbridge_burst #(.PER_W(PER_W), .CYC_W(CYC_W), .MIN_DEAD(MIN_DEAD)) u_dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .cfgPeriod(cfgPeriod),
    .cfgDead(cfgDead), .cfgTrim(cfgTrim), .cfgCycles(cfgCycles),
    .bridgeHi(bridgeHi), .bridgeLo(bridgeLo), .bridgeEn(bridgeEn), .burstDone(burstDone)
  );

  // R5 clamps
  function automatic int effPer(int p);
    return (p < 4*MIN_DEAD) ? 4*MIN_DEAD : p;
  endfunction
  function automatic int effDead(int d);
    return (d < MIN_DEAD) ? MIN_DEAD : d;
  endfunction
  // R3 first-half window
  function automatic logic expHi(int c, int p, int d, int t);
    return (c >= d) && (c + t < p/2);
  endfunction
  // R4 second-half window
  function automatic logic expLo(int c, int p, int d, int t);
    return (c >= p/2 + d) && (c + t < p);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkQuiet(string tag);
    chk({tag, " hi"}, bridgeHi, 1'b0);
    chk({tag, " lo"}, bridgeLo, 1'b0);
    chk({tag, " en"}, bridgeEn, 1'b0);
    chk({tag, " done"}, burstDone, 1'b0);
  endtask

  // Runs one burst from a negedge; disturb pulses start and rewrites config mid-burst (R9)
  task automatic runBurst(int p, int d, int t, int n, bit disturb);
    int pe = effPer(p);
    int de = effDead(d);
    int total = n * pe;
    cfgPeriod = PER_W'(p); cfgDead = PER_W'(d); cfgTrim = PER_W'(t); cfgCycles = CYC_W'(n);
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    chkQuiet("R1 launch window");
    for (int j = 0; j < total; j++) begin
      @(negedge clk);
      startIn = 1'b0;
      chk("R3 bridgeHi", bridgeHi, expHi(j % pe, pe, de, t));
      chk("R4 bridgeLo", bridgeLo, expLo(j % pe, pe, de, t));
      chk("R1 bridgeEn", bridgeEn, 1'b1);
      chk("R6 R7 burstDone", burstDone, (j == total - 1));
      if (disturb && (j == total / 2)) begin
        startIn = 1'b1;
        cfgPeriod = PER_W'(16 + $urandom % 50);
        cfgDead = PER_W'($urandom % 9);
        cfgTrim = PER_W'($urandom % 5);
        cfgCycles = CYC_W'(1 + $urandom % 3);
      end
    end
    @(negedge clk);
    chkQuiet("R6 R7 after burst");
    if (disturb) chkQuiet("R9 ignored start");
  endtask

  initial begin
    int seedInit;
    seedInit = $urandom(32'h5EED1);
    repeat (3) @(negedge clk);
    chkQuiet("R10 in reset");
    rstN = 1'b1;
    @(negedge clk);
    chkQuiet("R10 after reset");

    runBurst(1000, 50, 0, 20, 1'b0);   // nominal 100 kHz, 0.5 us dead, 20 cycles
    runBurst(1000, 50, 120, 2, 1'b0);  // trimmed power
    runBurst(40, 0, 0, 3, 1'b0);       // R5 dead clamp
    runBurst(5, 2, 0, 2, 1'b0);        // R5 period clamp
    runBurst(33, 6, 3, 2, 1'b0);       // odd period
    runBurst(40, 30, 0, 1, 1'b0);      // dead beyond half: no drive
    runBurst(100, 10, 5, 5, 1'b1);     // R9 disturbance

    // R8 zero cycles ignored
    cfgPeriod = PER_W'(50); cfgDead = PER_W'(5); cfgTrim = '0; cfgCycles = '0;
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    for (int i = 0; i < 8; i++) begin
      chkQuiet("R8 zero cycles");
      @(negedge clk);
    end

    for (int b = 0; b < 14; b++) begin
      runBurst(8 + $urandom % 190, $urandom % 20, $urandom % 30,
               1 + $urandom % 6, ($urandom % 3) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule